// File: doc/BRIEF.md
# Multithreaded Instruction Thread Selector

This block decides, every clock cycle, which of several hardware threads feeds the next instruction into one shared pipeline. It keeps a separate program counter for each thread. It presents the chosen thread's number and fetch address together with a valid flag. The choice is combinational from the current ready and stall inputs, so a change of thread costs no extra cycle.

A static mode input picks one of two switching policies. The interleaved policy rotates to a different ready thread after every issued instruction and steps around any thread that is stalled. The block policy stays on one thread until that thread suffers a long-latency stall, such as a miss in the outer cache level. It then moves on to another ready thread. A short stall on the running thread, such as a data hazard, leaves the pipeline idle without a switch.

The surrounding fetch logic raises an advance input when the selected instruction has really been taken. Only then does the selected thread's counter move forward.

Top module: `thread_issue_sel`

## Requirements
- R1: Each of the NTHR threads (default 4) has its own program counter. Reset loads thread t's counter with BASE_ADDR + t*BASE_STRIDE (defaults 0x1000 and 0x1000, so thread 0 starts at 0x1000 and thread 3 at 0x4000). The selection and fetch_pc follow the current inputs in the same cycle, without a dead cycle on a switch.
- R2: With mode_coarse = 0, the selector searches round-robin starting at the thread after the last selected one. After reset, the search starts at thread 0, so with all threads ready the order is 0,1,2,3,0,... When more than one thread is eligible, two consecutive issues never come from the same thread.
- R3: A thread is eligible when its ready bit is 1 and its stall bit is 0. Stalled or not-ready threads are skipped, and an issued thread is always eligible.
- R4: When no thread qualifies for issue, issue_valid is 0 and issue_tid is 0. The rotation pointer is held.
- R5: With mode_coarse = 1, the current thread keeps issuing while it is eligible, even when other threads are eligible. After reset, the current thread is thread 0.
- R6: With mode_coarse = 1, a short stall on the current thread (stall bit 1, long bit 0) gives issue_valid = 0 and no switch. A short stall on any other thread does not disturb the current thread.
- R7: With mode_coarse = 1, a long stall (stall bit 1, long bit 1) on the current thread switches to the next eligible thread after it in round-robin order, in the same cycle. A current thread that is not ready and not stalled also causes this switch. A long-stalled thread becomes eligible again once its stall bit clears.
- R8: A thread's counter increases by PC_STEP (default 4) at a clock edge only when that thread is issued with issue_valid = 1 and fetch_advance = 1. Otherwise it holds, including when advance is raised while nothing is issued.
- R9: Bit t of thr_ready, thr_stall and thr_stall_long belongs to thread t, and thread numbers are binary on issue_tid. Both modes share the record of the last issued thread, so changing the mode carries on from that thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_coarse | input | 1 | 0 = switch every cycle, 1 = switch only on a long stall |
| thr_ready | input | NTHR | Thread has an instruction available |
| thr_stall | input | NTHR | Thread is stalled |
| thr_stall_long | input | NTHR | Stall type: 1 = long latency, 0 = short |
| fetch_advance | input | 1 | The issued instruction was taken this cycle |
| issue_tid | output | TIDW | Selected thread number |
| fetch_pc | output | PCW | Program counter of the selected thread |
| issue_valid | output | 1 | A thread was selected this cycle |

## Verification
The bench targets the wrap of the rotation pointer and the case where only one thread is eligible. A design that wrapped wrongly would skip a thread or restart at thread 0, and one that refused to re-pick the last thread would report a spurious idle cycle.

In block mode the bench separates short from long stalls on the current thread. It also covers a short stall on some other thread and a current thread that simply stops being ready. A design that confused these cases would switch on a hazard or hang on a thread that has no work.

The bench raises advance during idle cycles and during non-advancing issues, and it applies a reset in the middle of the run. A counter that stepped at those times, or that failed to return to its base, shows up in a later fetch address.

// File: rtl/thrsel_pkg.sv
package thrsel_pkg;

  // Reset value of a thread's program counter.
  function automatic logic [63:0] thread_base(input int unsigned tid,
                                              input logic [63:0] base,
                                              input logic [63:0] stride);
    return base + 64'(tid) * stride;
  endfunction

  // Counter value after one issued-and-taken instruction.
  function automatic logic [63:0] pc_bump(input logic [63:0] pc,
                                          input logic [63:0] step);
    return pc + step;
  endfunction

  // Thread index reached k positions after 'from', wrapping at n.
  function automatic int unsigned ring_step(input int unsigned from,
                                            input int unsigned k,
                                            input int unsigned n);
    return (from + k) % n;
  endfunction

endpackage

// File: rtl/thrsel_rr_find.sv
module thrsel_rr_find #(
  parameter int NTHR = 4,
  parameter int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic [NTHR-1:0] cand_mask,
  input  logic [TIDW-1:0] start_after,
  output logic            hit,
  output logic [TIDW-1:0] hit_tid
);
  import thrsel_pkg::*;

  // Scan the positions after start_after; start_after itself comes last.
  always_comb begin
    hit     = 1'b0;
    hit_tid = '0;
    for (int k = 1; k <= NTHR; k++) begin
      int unsigned idx;
      idx = ring_step(int'(start_after), k, NTHR);
      if (!hit && cand_mask[idx]) begin
        hit     = 1'b1;
        hit_tid = TIDW'(idx);
      end
    end
  end

  always_comb begin
    if (hit) assert_hit_is_candidate_R3: assert (cand_mask[hit_tid]);
    if (cand_mask != '0) assert_finds_when_any_R4: assert (hit);
  end

endmodule

// File: rtl/thrsel_policy.sv
module thrsel_policy #(
  parameter int NTHR = 4,
  parameter int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_coarse,
  input  logic [NTHR-1:0] thr_ready,
  input  logic [NTHR-1:0] thr_stall,
  input  logic [NTHR-1:0] thr_stall_long,
  output logic [TIDW-1:0] pick_tid,
  output logic            pick_valid
);

  localparam logic [TIDW-1:0] LAST_INIT = TIDW'(NTHR - 1);

  logic [TIDW-1:0] last_q;      // last issued thread (interleaved search)
  logic [TIDW-1:0] cur_q;       // running thread (block mode)
  logic [NTHR-1:0] eligible;

  logic            fine_hit, blk_hit;
  logic [TIDW-1:0] fine_tid, blk_tid;

  // Named events for the checks.
  logic cur_eligible, cur_short_stall, blk_keep_evt, blk_idle_evt, blk_switch_evt;

  assign eligible        = thr_ready & ~thr_stall;
  assign cur_eligible    = eligible[cur_q];
  assign cur_short_stall = thr_stall[cur_q] & ~thr_stall_long[cur_q];

  thrsel_rr_find #(.NTHR(NTHR), .TIDW(TIDW)) u_fine (
    .cand_mask  (eligible),
    .start_after(last_q),
    .hit        (fine_hit),
    .hit_tid    (fine_tid)
  );

  thrsel_rr_find #(.NTHR(NTHR), .TIDW(TIDW)) u_blk (
    .cand_mask  (eligible),
    .start_after(cur_q),
    .hit        (blk_hit),
    .hit_tid    (blk_tid)
  );

  assign blk_keep_evt   = mode_coarse & cur_eligible;
  assign blk_idle_evt   = mode_coarse & ~cur_eligible & cur_short_stall;
  assign blk_switch_evt = mode_coarse & ~cur_eligible & ~cur_short_stall & blk_hit;

  always_comb begin
    pick_valid = 1'b0;
    pick_tid   = '0;
    if (mode_coarse) begin
      if (cur_eligible) begin
        pick_valid = 1'b1;
        pick_tid   = cur_q;
      end else if (!cur_short_stall && blk_hit) begin
        pick_valid = 1'b1;
        pick_tid   = blk_tid;
      end
    end else if (fine_hit) begin
      pick_valid = 1'b1;
      pick_tid   = fine_tid;
    end
  end

  // Both records follow every issue, so a mode change continues smoothly.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= LAST_INIT;
      cur_q  <= '0;
    end else if (pick_valid) begin
      last_q <= pick_tid;
      cur_q  <= pick_tid;
    end
  end

  assert_issue_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> eligible[pick_tid]);

  assert_none_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eligible == '0) |-> (!pick_valid && pick_tid == '0));

  assert_fine_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_coarse && pick_valid && $countones(eligible) > 1)
      |=> ((!mode_coarse && pick_valid && $past(pick_valid) && !$past(mode_coarse))
           -> (pick_tid != $past(pick_tid)) ));

  assert_blk_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_keep_evt |=> (mode_coarse && eligible[$past(pick_tid)]) -> (pick_valid && pick_tid == $past(pick_tid)));

  assert_blk_short_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_idle_evt |-> !pick_valid);

  assert_blk_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_switch_evt |-> (pick_valid && pick_tid != cur_q));

  assert_hold_pointer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_valid |=> ($stable(last_q) && $stable(cur_q)));

endmodule

// File: rtl/thrsel_pc_bank.sv
module thrsel_pc_bank #(
  parameter int          NTHR        = 4,
  parameter int          TIDW        = (NTHR > 1) ? $clog2(NTHR) : 1,
  parameter int          PCW         = 32,
  parameter logic [63:0] BASE_ADDR   = 64'h1000,
  parameter logic [63:0] BASE_STRIDE = 64'h1000,
  parameter logic [63:0] PC_STEP     = 64'd4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TIDW-1:0] issue_tid,
  input  logic            issue_valid,
  input  logic            fetch_advance,
  output logic [PCW-1:0]  fetch_pc
);
  import thrsel_pkg::*;

  logic [PCW-1:0]  pc_q [NTHR];
  logic [NTHR-1:0] step_en;
  logic [NTHR-1:0] stepped_q;   // step_en of the previous cycle, for the checks

  for (genvar t = 0; t < NTHR; t++) begin : g_ctx
    localparam logic [PCW-1:0] RST_PC = PCW'(thread_base(t, BASE_ADDR, BASE_STRIDE));

    assign step_en[t] = issue_valid & fetch_advance & (issue_tid == TIDW'(t));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pc_q[t]      <= RST_PC;
        stepped_q[t] <= 1'b0;
      end else begin
        stepped_q[t] <= step_en[t];
        if (step_en[t]) pc_q[t] <= PCW'(pc_bump(64'(pc_q[t]), PC_STEP));
      end
    end

    assert_pc_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stepped_q[t] |-> (pc_q[t] == $past(pc_q[t]) + PCW'(PC_STEP)));

    assert_pc_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !stepped_q[t] |-> $stable(pc_q[t]));
  end

  assign fetch_pc = pc_q[issue_tid];

  always_comb begin
    assert_one_stepper_R8: assert ($onehot0(step_en));
  end

endmodule

// File: rtl/thread_issue_sel.sv
module thread_issue_sel #(
  parameter int          NTHR        = 4,
  parameter int          TIDW        = (NTHR > 1) ? $clog2(NTHR) : 1,
  parameter int          PCW         = 32,
  parameter logic [63:0] BASE_ADDR   = 64'h1000,
  parameter logic [63:0] BASE_STRIDE = 64'h1000,
  parameter logic [63:0] PC_STEP     = 64'd4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_coarse,
  input  logic [NTHR-1:0] thr_ready,
  input  logic [NTHR-1:0] thr_stall,
  input  logic [NTHR-1:0] thr_stall_long,
  input  logic            fetch_advance,
  output logic [TIDW-1:0] issue_tid,
  output logic [PCW-1:0]  fetch_pc,
  output logic            issue_valid
);

  logic [TIDW-1:0] pick_tid;
  logic            pick_valid;

  thrsel_policy #(.NTHR(NTHR), .TIDW(TIDW)) u_policy (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_coarse   (mode_coarse),
    .thr_ready     (thr_ready),
    .thr_stall     (thr_stall),
    .thr_stall_long(thr_stall_long),
    .pick_tid      (pick_tid),
    .pick_valid    (pick_valid)
  );

  thrsel_pc_bank #(
    .NTHR(NTHR), .TIDW(TIDW), .PCW(PCW),
    .BASE_ADDR(BASE_ADDR), .BASE_STRIDE(BASE_STRIDE), .PC_STEP(PC_STEP)
  ) u_pcs (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_tid    (pick_tid),
    .issue_valid  (pick_valid),
    .fetch_advance(fetch_advance),
    .fetch_pc     (fetch_pc)
  );

  assign issue_tid   = pick_tid;
  assign issue_valid = pick_valid;

  // R1: a switch never costs a dead cycle when the next thread is ready.
  assert_no_bubble_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_coarse && ((thr_ready & ~thr_stall) != '0)) |-> issue_valid);

endmodule

// File: tb/sim_thread_issue_sel.sv
module sim_thread_issue_sel;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  // Vector layout (R9 encoding, bit t = thread t):
  // [16] mode_coarse, [15:12] ready, [11:8] stall, [7:4] long,
  // [3] advance, [2] expected valid, [1:0] expected thread
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 4'b1111, 4'b0000, 4'b0000, 1'b1, 1'b1, 2'd0},
    {1'b0, 4'b1111, 4'b0000, 4'b0000, 1'b1, 1'b1, 2'd1},
    {1'b0, 4'b1111, 4'b0000, 4'b0000, 1'b1, 1'b1, 2'd2},
    {1'b0, 4'b1111, 4'b0000, 4'b0000, 1'b1, 1'b1, 2'd3},
    {1'b0, 4'b1111, 4'b0000, 4'b0000, 1'b1, 1'b1, 2'd0},
    {1'b0, 4'b1111, 4'b0010, 4'b0000, 1'b1, 1'b1, 2'd2},
    {1'b0, 4'b1111, 4'b1000, 4'b1000, 1'b1, 1'b1, 2'd0},
    {1'b0, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd0},
    {1'b0, 4'b1000, 4'b0000, 4'b0000, 1'b1, 1'b1, 2'd3},
    {1'b0, 4'b1000, 4'b0000, 4'b0000, 1'b1, 1'b1, 2'd3},
    {1'b0, 4'b0101, 4'b0000, 4'b0000, 1'b0, 1'b1, 2'd0},
    {1'b0, 4'b0101, 4'b0000, 4'b0000, 1'b1, 1'b1, 2'd2},
    {1'b1, 4'b1111, 4'b0000, 4'b0000, 1'b1, 1'b1, 2'd2},
    {1'b1, 4'b1111, 4'b0000, 4'b0000, 1'b1, 1'b1, 2'd2},
    {1'b1, 4'b1111, 4'b0100, 4'b0000, 1'b1, 1'b0, 2'd0},
    {1'b1, 4'b1111, 4'b0100, 4'b0100, 1'b1, 1'b1, 2'd3},
    {1'b1, 4'b1111, 4'b0000, 4'b0000, 1'b1, 1'b1, 2'd3},
    {1'b1, 4'b1110, 4'b1000, 4'b1000, 1'b1, 1'b1, 2'd1},
    {1'b1, 4'b1101, 4'b0000, 4'b0000, 1'b1, 1'b1, 2'd2},
    {1'b1, 4'b1111, 4'b1111, 4'b1111, 1'b1, 1'b0, 2'd0},
    {1'b1, 4'b1111, 4'b1000, 4'b0000, 1'b1, 1'b1, 2'd2},
    {1'b0, 4'b1111, 4'b0000, 4'b0000, 1'b1, 1'b1, 2'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_coarse = 1'b0;
  logic [3:0]  thr_ready = '0, thr_stall = '0, thr_stall_long = '0;
  logic        fetch_advance = 1'b0;
  logic [1:0]  issue_tid;
  logic [31:0] fetch_pc;
  logic        issue_valid;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] pc_model [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  thread_issue_sel u0 (
    .clk(clk), .rst_n(rst_n), .mode_coarse(mode_coarse),
    .thr_ready(thr_ready), .thr_stall(thr_stall), .thr_stall_long(thr_stall_long),
    .fetch_advance(fetch_advance),
    .issue_tid(issue_tid), .fetch_pc(fetch_pc), .issue_valid(issue_valid)
  );

  function automatic string vec_tag(input int i);
    if (i == 7)                  return "R4";
    if (i == 5 || i == 6)        return "R3";
    if (i == 10)                 return "R8";
    if (i < 12 || i == 21)       return "R2";
    if (i == 12 || i == 13 || i == 16 || i == 20) return "R5";
    if (i == 14)                 return "R6";
    if (i == 19)                 return "R7";
    return "R7";
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic reset_model();
    for (int t = 0; t < 4; t++) pc_model[t] = 32'h1000 * (t + 1);   // R1 base
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    mode_coarse = 1'b0; thr_ready = '0; thr_stall = '0; thr_stall_long = '0;
    fetch_advance = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    reset_model();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    #1;
    // Reset state: nothing ready, so idle with thread 0 (R4)
    check("R4", "reset valid", 32'(issue_valid), 32'd0);
    check("R4", "reset tid", 32'(issue_tid), 32'd0);

    // Table walk: R2, R3, R4, R5, R6, R7, R8, R9
    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      @(negedge clk);
      v = VEC[i];
      mode_coarse    = v[16];
      thr_ready      = v[15:12];
      thr_stall      = v[11:8];
      thr_stall_long = v[7:4];
      fetch_advance  = v[3];
      #1;
      check(vec_tag(i), $sformatf("vec %0d valid", i), 32'(issue_valid), 32'(v[2]));
      check(vec_tag(i), $sformatf("vec %0d tid", i), 32'(issue_tid), 32'(v[1:0]));
      if (v[2]) begin
        check("R8", $sformatf("vec %0d pc", i), fetch_pc, pc_model[v[1:0]]);
        if (v[3]) pc_model[v[1:0]] = pc_model[v[1:0]] + 32'd4;
      end
    end

    // Mid-run reset: every counter back to its base, order restarts at 0 (R1, R2)
    do_reset();
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      thr_ready = 4'b1111;
      fetch_advance = 1'b0;
      #1;
      check("R2", "post-reset order", 32'(issue_tid), 32'(t));
      check("R1", "post-reset base pc", fetch_pc, pc_model[t]);
    end

    // Advance during idle leaves counters unchanged (R8)
    @(negedge clk);
    thr_ready = 4'b0000; fetch_advance = 1'b1;
    #1;
    check("R4", "idle valid", 32'(issue_valid), 32'd0);
    @(negedge clk);
    thr_ready = 4'b0001; fetch_advance = 1'b0;
    #1;
    check("R8", "pc after idle advance", fetch_pc, pc_model[0]);

    // Block mode after reset starts on thread 0 even if others are ready (R5)
    do_reset();
    @(negedge clk);
    mode_coarse = 1'b1; thr_ready = 4'b1111; fetch_advance = 1'b1;
    #1;
    check("R5", "block start tid", 32'(issue_tid), 32'd0);
    @(negedge clk);
    #1;
    check("R5", "block stays tid", 32'(issue_tid), 32'd0);
    check("R8", "block stepped pc", fetch_pc, pc_model[0] + 32'd4);

    // Long stall clears: thread becomes eligible again (R7)
    @(negedge clk);
    thr_stall = 4'b0001; thr_stall_long = 4'b0001;
    #1;
    check("R7", "switch off long stall", 32'(issue_tid), 32'd1);
    @(negedge clk);
    thr_stall = 4'b0000; thr_stall_long = 4'b0000; thr_ready = 4'b0001;
    #1;
    check("R7", "stalled thread returns", 32'(issue_tid), 32'd0);

    finish_run();
  end

endmodule